// File: doc/BRIEF.md
# I2C Register-Write Target

This block is the target side of an I2C link inside a control peripheral. It watches the open-drain clock and data lines, finds start and stop conditions, and takes a short write transfer. The transfer is a device address byte, then a register select byte, then a data byte, and the data byte goes into an internal bank of byte-wide registers. Each byte this target accepts is answered by pulling the data line low for the ninth clock.

One register of the bank is brought out as a parallel control word, for example a brightness level for an analog stage. Both lines pass through a synchroniser into the system clock domain, so the system clock must run at least eight times faster than the bus clock. The block never drives a line high. It only asserts a pull-down request, and outside logic turns that request into an open-drain output.

Top module: `i2c_regwr_target`

## Requirements
- R1: After reset the pull-down request is deasserted and every register of the bank, including the control output, reads zero.
- R2: A start is the data line falling while the clock line is high, and a stop is the data line rising while the clock line is high. Data line changes made while the clock line is low are data bits, sampled while the clock line is high.
- R3: The first byte after a start is received most significant bit first. Bits 7..1 hold the device address and bit 0 is the direction flag, with 0 meaning write. When bits 7..1 equal 7'b1100000 (byte 8'hC0), the target pulls the data line low during the ninth clock.
- R4: The target only requests a pull-down or releases the line. That request changes only while the synchronised clock line is low.
- R5: On an address mismatch the data line stays released for that ninth clock. Every later byte up to the next start or stop is then neither acknowledged nor written.
- R6: A matching address with the direction flag set to 1 (read) is ignored. It gets no acknowledge, no later byte is acknowledged, and nothing is written.
- R7: The second byte is the register select and the third byte is the data, and both are acknowledged. The data is written at the end of the data byte's ninth clock. The control output shows register 8'h22 one system clock after that write.
- R8: A write to any register other than 8'h22 leaves the control output unchanged.
- R9: A start seen at any point, including a repeated start in the middle of a byte, clears the bit count and returns the target to address reception. A partially received byte is then dropped.
- R10: A stop returns the target to idle. A data byte cut short by a stop is not written, and bytes clocked after a stop without a new start are not acknowledged.
- R11: Bytes that follow the data byte in the same transfer are neither acknowledged nor written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the bus clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin (wired-AND level) |
| sda_pull_o | output | 1 | 1 requests the data line be pulled low, 0 releases it |
| level_o | output | DW | Contents of the control register 8'h22 |

## Verification
The bench goes after the points where the transfer shape breaks. These are a mismatched or read address, a repeated start part-way through a data byte, a stop that cuts a byte short, bytes clocked after a stop with no new start, and a fourth byte after the data byte. A design that counted the clock fall closing a start condition as a bit would be off by one, and would acknowledge on the wrong clock. A design that did not clear its count on a start would write a stale value after a repeated start. One that committed data on the eighth bit instead of after the acknowledge would write the byte that a stop abandoned. Writes to a register other than 8'h22 are checked against the control output, so a design that decodes the register select loosely and aliases the address shows up as a changed output.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_SUB,
      ST_DATA,
      ST_SKIP
   } tgt_state_e;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_lvl,
   output logic sda_lvl,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);

   // chain of resynchronising flops per line, idle level is high
   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      logic scl_q;
      logic sda_q;
      if (g == 0) begin : g_head
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_q <= 1'b1;
               sda_q <= 1'b1;
            end else begin
               scl_q <= scl_i;
               sda_q <= sda_i;
            end
         end
      end else begin : g_tail
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_q <= 1'b1;
               sda_q <= 1'b1;
            end else begin
               scl_q <= g_stage[g-1].scl_q;
               sda_q <= g_stage[g-1].sda_q;
            end
         end
      end
   end

   logic scl_prev;
   logic sda_prev;

   assign scl_lvl = g_stage[STAGES-1].scl_q;
   assign sda_lvl = g_stage[STAGES-1].sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_prev <= 1'b1;
         sda_prev <= 1'b1;
      end else begin
         scl_prev <= scl_lvl;
         sda_prev <= sda_lvl;
      end
   end

   assign scl_rise  =  scl_lvl & ~scl_prev;
   assign scl_fall  = ~scl_lvl &  scl_prev;
   assign start_det =  scl_lvl &  scl_prev &  sda_prev & ~sda_lvl;
   assign stop_det  =  scl_lvl &  scl_prev & ~sda_prev &  sda_lvl;

endmodule

// File: rtl/i2c_frame_ctrl.sv
module i2c_frame_ctrl
   import i2c_tgt_pkg::*;
#(
   parameter int          DW       = 8,
   parameter int          AW       = 8,
   parameter logic [DW-2:0] DEV_ADDR = 7'h60
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          scl_rise,
   input  logic          scl_fall,
   input  logic          sda_lvl,
   input  logic          start_det,
   input  logic          stop_det,
   output logic          sda_pull,
   output logic          wr_en,
   output logic [AW-1:0] wr_addr,
   output logic [DW-1:0] wr_data,
   output tgt_state_e    state
);

   localparam int CW = $clog2(DW + 2);
   localparam logic [CW-1:0] BYTE_DONE = CW'(DW);
   localparam logic [CW-1:0] ACK_DONE  = CW'(DW + 1);

   logic [CW-1:0] bit_cnt;
   logic [DW-1:0] shreg;
   logic [DW-1:0] sub_q;
   logic          ack_q;
   logic          active;

   assign active  = (state == ST_ADDR) || (state == ST_SUB) || (state == ST_DATA);
   assign wr_addr = sub_q[AW-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         bit_cnt  <= '0;
         shreg    <= '0;
         sub_q    <= '0;
         wr_data  <= '0;
         ack_q    <= 1'b0;
         sda_pull <= 1'b0;
         wr_en    <= 1'b0;
      end else begin
         wr_en <= 1'b0;
         if (start_det) begin
            state    <= ST_ADDR;
            bit_cnt  <= '0;
            sda_pull <= 1'b0;
         end else if (stop_det) begin
            state    <= ST_IDLE;
            bit_cnt  <= '0;
            sda_pull <= 1'b0;
         end else if (active) begin
            if (scl_rise) begin
               if (bit_cnt < BYTE_DONE) begin
                  shreg <= {shreg[DW-2:0], sda_lvl};
               end
               if (bit_cnt < ACK_DONE) begin
                  bit_cnt <= bit_cnt + CW'(1);
               end
            end else if (scl_fall) begin
               if (bit_cnt == BYTE_DONE) begin
                  // last data bit just ended: decide the acknowledge
                  unique case (state)
                     ST_ADDR: begin
                        ack_q    <= (shreg[DW-1:1] == DEV_ADDR) && !shreg[0];
                        sda_pull <= (shreg[DW-1:1] == DEV_ADDR) && !shreg[0];
                     end
                     ST_SUB: begin
                        sub_q    <= shreg;
                        ack_q    <= 1'b1;
                        sda_pull <= 1'b1;
                     end
                     default: begin
                        wr_data  <= shreg;
                        ack_q    <= 1'b1;
                        sda_pull <= 1'b1;
                     end
                  endcase
               end else if (bit_cnt == ACK_DONE) begin
                  // ninth clock ended: release and advance
                  sda_pull <= 1'b0;
                  bit_cnt  <= '0;
                  unique case (state)
                     ST_ADDR: state <= ack_q ? ST_SUB : ST_SKIP;
                     ST_SUB:  state <= ST_DATA;
                     default: begin
                        wr_en <= 1'b1;
                        state <= ST_SKIP;
                     end
                  endcase
               end
            end
         end
      end
   end

endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank #(
   parameter int          AW         = 8,
   parameter int          DW         = 8,
   parameter logic [AW-1:0] LEVEL_ADDR = 8'h22
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   output logic [DW-1:0] level_o
);

   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] regs [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) begin
            regs[i] <= '0;
         end
      end else if (wr_en) begin
         regs[wr_addr] <= wr_data;
      end
   end

   assign level_o = regs[LEVEL_ADDR];

endmodule

// File: rtl/i2c_regwr_target.sv
module i2c_regwr_target
   import i2c_tgt_pkg::*;
#(
   parameter int              DW          = 8,
   parameter int              REG_AW      = 8,
   parameter int              SYNC_STAGES = 2,
   parameter logic [DW-2:0]   DEV_ADDR    = 7'h60,
   parameter logic [REG_AW-1:0] LEVEL_ADDR = 8'h22
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          scl_i,
   input  logic          sda_i,
   output logic          sda_pull_o,
   output logic [DW-1:0] level_o
);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (REG_AW > DW) begin : g_bad_aw
      $error("register select must fit in one byte");
   end
   if (DW < 2) begin : g_bad_dw
      $error("DW too small");
   end

   logic            scl_lvl;
   logic            sda_lvl;
   logic            scl_rise;
   logic            scl_fall;
   logic            start_det;
   logic            stop_det;
   logic            wr_en;
   logic [REG_AW-1:0] wr_addr;
   logic [DW-1:0]   wr_data;
   tgt_state_e      fsm_state;

   i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .scl_lvl   (scl_lvl),
      .sda_lvl   (sda_lvl),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   i2c_frame_ctrl #(.DW(DW), .AW(REG_AW), .DEV_ADDR(DEV_ADDR)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .sda_lvl   (sda_lvl),
      .start_det (start_det),
      .stop_det  (stop_det),
      .sda_pull  (sda_pull_o),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .state     (fsm_state)
   );

   i2c_reg_bank #(.AW(REG_AW), .DW(DW), .LEVEL_ADDR(LEVEL_ADDR)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .level_o (level_o)
   );

endmodule

// File: rtl/i2c_regwr_target_chk.sv
module i2c_regwr_target_chk
   import i2c_tgt_pkg::*;
#(
   parameter int              DW         = 8,
   parameter int              AW         = 8,
   parameter logic [AW-1:0]   LEVEL_ADDR = 8'h22
) (
   input logic          clk,
   input logic          rst_n,
   input logic          scl_lvl,
   input logic          start_det,
   input logic          stop_det,
   input logic          sda_pull_o,
   input logic          wr_en,
   input logic [AW-1:0] wr_addr,
   input logic [DW-1:0] wr_data,
   input logic [DW-1:0] level_o,
   input tgt_state_e    fsm_state
);

   // R4
   pull_edge_low_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_pull_o) |-> !scl_lvl);

   // R5
   skip_never_pulls_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fsm_state == ST_SKIP) |-> !sda_pull_o);

   // R7
   level_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == LEVEL_ADDR) |=> (level_o == $past(wr_data)));

   // R8
   other_write_keeps_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr != LEVEL_ADDR) |=> $stable(level_o));

   // R9
   start_to_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> (fsm_state == ST_ADDR) && !sda_pull_o);

   // R10
   stop_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> (fsm_state == ST_IDLE) && !sda_pull_o);

   // R11
   write_only_from_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> ($past(fsm_state) == ST_DATA) && (fsm_state == ST_SKIP));

endmodule

bind i2c_regwr_target i2c_regwr_target_chk #(
   .DW(DW), .AW(REG_AW), .LEVEL_ADDR(LEVEL_ADDR)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .scl_lvl    (scl_lvl),
   .start_det  (start_det),
   .stop_det   (stop_det),
   .sda_pull_o (sda_pull_o),
   .wr_en      (wr_en),
   .wr_addr    (wr_addr),
   .wr_data    (wr_data),
   .level_o    (level_o),
   .fsm_state  (fsm_state)
);

// File: tb/sim_i2c_regwr_target.sv
module sim_i2c_regwr_target;

   localparam int Q = 10;          // quarter bus period in system clocks
   localparam logic [6:0] DEV = 7'h60;
   localparam logic [7:0] LVL = 8'h22;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic       rst_n   = 1'b0;
   logic       scl_drv = 1'b1;
   logic       sda_drv = 1'b1;
   logic       sda_pull;
   logic [7:0] level;
   logic       sda_bus;

   assign sda_bus = sda_drv & ~sda_pull;

   i2c_regwr_target u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_i      (scl_drv),
      .sda_i      (sda_bus),
      .sda_pull_o (sda_pull),
      .level_o    (level)
   );

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   bit done   = 1'b0;

   // behavioural reference model state
   bit         model_on  = 1'b0;
   bit         exp_pull  = 1'b0;
   logic [7:0] exp_level = 8'h00;
   int         settle    = 0;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // per-clock comparison against the model, away from the edges
   always @(posedge clk) begin
      cyc++;
      #2;
      if (settle > 0) begin
         settle--;
      end else if (model_on && !done) begin
         check(sda_pull == exp_pull, "R4 model pull", int'(sda_pull), int'(exp_pull));
         check(level == exp_level, "R7 model level", int'(level), int'(exp_level));
      end
   end

   // watchdog
   always @(posedge clk) begin
      if (cyc > 150000 && !done) begin
         done = 1'b1;
         fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   task automatic waitc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic sda_set(input bit v);
      sda_drv = v;
      waitc(Q);
   endtask

   task automatic scl_set(input bit v);
      scl_drv = v;
      settle  = 8;
      waitc(Q);
   endtask

   task automatic start_c();
      sda_set(1'b1);
      scl_set(1'b1);
      sda_set(1'b0);
      scl_set(1'b0);
   endtask

   task automatic stop_c();
      sda_set(1'b0);
      scl_set(1'b1);
      sda_set(1'b1);
   endtask

   task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string tag,
                            input bit commit, input logic [7:0] sub);
      for (int i = 7; i >= 0; i--) begin
         sda_set(b[i]);
         scl_set(1'b1);
         waitc(Q);
         if (i == 0) exp_pull = exp_ack;
         scl_set(1'b0);
      end
      sda_set(1'b1);
      scl_set(1'b1);
      check(sda_bus == !exp_ack, tag, int'(sda_bus), int'(!exp_ack));
      waitc(Q);
      exp_pull = 1'b0;
      if (commit && sub == LVL) exp_level = b;
      scl_set(1'b0);
   endtask

   task automatic partial_bits(input logic [7:0] b, input int n);
      for (int i = 7; i > 7 - n; i--) begin
         sda_set(b[i]);
         scl_set(1'b1);
         waitc(Q);
         scl_set(1'b0);
      end
   endtask

   task automatic write_txn(input logic [6:0] a, input bit rd, input logic [7:0] sub,
                            input logic [7:0] d, input string tag);
      bit ok;
      ok = (a == DEV) && !rd;
      start_c();
      send_byte({a, rd}, ok, tag, 1'b0, 8'h00);
      send_byte(sub, ok, tag, 1'b0, 8'h00);
      send_byte(d, ok, tag, ok, sub);
      stop_c();
   endtask

   initial begin
      logic [7:0] pats [6] = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h80, 8'h01};
      waitc(5);
      // R1 reset state
      check(sda_pull == 1'b0, "R1 pull", int'(sda_pull), 0);
      check(level == 8'h00, "R1 level", int'(level), 0);
      rst_n = 1'b1;
      waitc(4);
      model_on = 1'b1;

      // R2 R3 R7 full-brightness write
      write_txn(DEV, 1'b0, LVL, 8'h3F, "R3 ack on write");
      waitc(4);
      check(level == 8'h3F, "R7 level 3F", int'(level), 8'h3F);

      // R7 several data patterns
      foreach (pats[k]) begin
         write_txn(DEV, 1'b0, LVL, pats[k], "R2 ack on pattern");
         waitc(4);
         check(level == pats[k], "R7 level pattern", int'(level), int'(pats[k]));
      end

      // R8 other register
      write_txn(DEV, 1'b0, 8'h10, 8'hC3, "R8 ack other reg");
      write_txn(DEV, 1'b0, 8'h23, 8'h77, "R8 ack neighbour reg");
      waitc(4);
      check(level == 8'h01, "R8 level kept", int'(level), 8'h01);

      // R5 address mismatch, low bit and high bit differing
      write_txn(7'h61, 1'b0, LVL, 8'h99, "R5 no ack mismatch");
      write_txn(7'h20, 1'b0, LVL, 8'h98, "R5 no ack mismatch msb");
      waitc(4);
      check(level == 8'h01, "R5 level kept", int'(level), 8'h01);

      // R6 read flag set
      write_txn(DEV, 1'b1, LVL, 8'h97, "R6 no ack on read");
      waitc(4);
      check(level == 8'h01, "R6 level kept", int'(level), 8'h01);

      // R9 repeated start in the middle of a data byte
      start_c();
      send_byte({DEV, 1'b0}, 1'b1, "R9 addr", 1'b0, 8'h00);
      send_byte(LVL, 1'b1, "R9 sub", 1'b0, 8'h00);
      partial_bits(8'h0F, 3);
      start_c();
      send_byte({DEV, 1'b0}, 1'b1, "R9 addr after restart", 1'b0, 8'h00);
      send_byte(LVL, 1'b1, "R9 sub after restart", 1'b0, 8'h00);
      send_byte(8'h77, 1'b1, "R9 data after restart", 1'b1, LVL);
      stop_c();
      waitc(4);
      check(level == 8'h77, "R9 level 77", int'(level), 8'h77);

      // R9 repeated start after a mismatch
      start_c();
      send_byte({7'h61, 1'b0}, 1'b0, "R9 mismatch before restart", 1'b0, 8'h00);
      start_c();
      send_byte({DEV, 1'b0}, 1'b1, "R9 addr restart", 1'b0, 8'h00);
      send_byte(LVL, 1'b1, "R9 sub restart", 1'b0, 8'h00);
      send_byte(8'h44, 1'b1, "R9 data restart", 1'b1, LVL);
      stop_c();
      waitc(4);
      check(level == 8'h44, "R9 level 44", int'(level), 8'h44);

      // R10 stop cuts data byte short, then bytes with no start
      start_c();
      send_byte({DEV, 1'b0}, 1'b1, "R10 addr", 1'b0, 8'h00);
      send_byte(LVL, 1'b1, "R10 sub", 1'b0, 8'h00);
      partial_bits(8'hEE, 5);
      stop_c();
      waitc(4);
      check(level == 8'h44, "R10 partial not written", int'(level), 8'h44);
      scl_set(1'b0);
      send_byte({DEV, 1'b0}, 1'b0, "R10 no ack after stop", 1'b0, 8'h00);
      send_byte(LVL, 1'b0, "R10 no ack after stop", 1'b0, 8'h00);
      send_byte(8'h12, 1'b0, "R10 no ack after stop", 1'b0, 8'h00);
      stop_c();
      waitc(4);
      check(level == 8'h44, "R10 level kept", int'(level), 8'h44);

      // R11 extra byte after the data byte
      start_c();
      send_byte({DEV, 1'b0}, 1'b1, "R11 addr", 1'b0, 8'h00);
      send_byte(LVL, 1'b1, "R11 sub", 1'b0, 8'h00);
      send_byte(8'h11, 1'b1, "R11 data", 1'b1, LVL);
      send_byte(8'h99, 1'b0, "R11 extra byte no ack", 1'b0, 8'h00);
      stop_c();
      waitc(4);
      check(level == 8'h11, "R11 level 11", int'(level), 8'h11);

      waitc(20);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule